// File: doc/BRIEF.md
# Sensitivity Map Lookup Engine

This engine classifies a single-bit configuration upset. It receives the upset location as a frame number, a byte offset within the frame and a bit offset within that byte. It then walks a compressed sensitivity map that sits in external memory. The result tells whether the flipped bit is used by the design. A used bit is reported as a critical error together with its region tag. An unused bit is reported as a non-critical error.

The map is read through a word-addressed 32-bit read master with waitrequest and readdatavalid, and one read is in flight at a time. After reset, the first lookup reads and validates a five-word map header. The header gives the layout of three arrays:
- a frame information array with one word per frame;
- an offset-map array of 16-bit entries;
- a packed sensitivity data array that holds tags 1, 2, 4 or 8 bits wide.

Later lookups reuse the header values and need three reads each.

Top module: `seu_map_lookup`

## Requirements
- R1: Header word 0 sits at word address HDR_ADDR. Its bits [23:0] must equal 0x445341. If they do not, `map_err_o` rises and the lookup reports critical with `region_o` = 0, after exactly one bus read.
- R2: Bits [31:24] of header word 0 give the revision. Values 1 and 2 are accepted; any other value is a map error, raised after one read. Revision 2 takes the offset-map length from header word 4 bits [15:0]. Revision 1 ignores that field and uses the parameter DEF_MAP_LEN.
- R3: Header words HDR_ADDR+1, +2 and +3 hold the word base addresses of the frame array, the offset-map array and the sensitivity array. Header word 4 bits [23:16] hold the tag width. Any tag width other than 1, 2, 4 or 8 is a map error, raised after five reads.
- R4: The frame word is read from frame base + frame number. Its bits [15:0] hold the offset-map index and its upper bits are ignored. An index of 0xFFFF ends the lookup as non-critical after that single read.
- R5: The offset-map entry lies at byte offset index × length + ((byte × 8) + bit) × 2. It is read from word address offset base + (offset >> 2). Bits [15:0] are taken when offset bit 1 is 0, and bits [31:16] otherwise.
- R6: The tag starts at bit position entry × width. It is read from word address sensitivity base + (position >> 5). Its bits are taken from bit position[4:0] of that word upward, least significant bit first.
- R7: A zero tag gives a one-cycle `noncrit_o` pulse. A non-zero tag gives a one-cycle `crit_o` pulse with the tag, zero-extended, on `region_o`. The two never occur together, and `region_o` is 0 whenever `crit_o` is low.
- R8: The read master holds `avm_address_o` and `avm_read_o` while `avm_waitrequest_i` is high. It keeps at most one read outstanding and takes data on `avm_readdatavalid_i`.
- R9: `err_ready_o` is high only when the engine is idle. It is low from the acceptance cycle through the result cycle and high again on the cycle after the result. No bus read is issued while the engine is idle.
- R10: The header is read only by the first lookup after reset, which needs 5 + 3 reads. Later lookups need 3 reads. Reset forces the header to be read again.
- R11: `map_err_o` stays high until reset. While it is high, every lookup reports critical with region 0 and issues no bus reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| err_valid_i | input | 1 | Error location valid |
| err_ready_o | output | 1 | Engine idle, ready to accept a location |
| err_frame_i | input | FRAME_W | Frame number |
| err_byte_i | input | BYTE_W | Byte offset within the frame |
| err_bit_i | input | 3 | Bit offset within the byte |
| crit_o | output | 1 | One-cycle critical result |
| noncrit_o | output | 1 | One-cycle non-critical result |
| region_o | output | 8 | Region tag, valid with crit_o |
| map_err_o | output | 1 | Map header invalid, sticky until reset |
| avm_address_o | output | ADDR_W | Read word address |
| avm_read_o | output | 1 | Read strobe |
| avm_readdata_i | input | 32 | Read data |
| avm_waitrequest_i | input | 1 | Slave stall |
| avm_readdatavalid_i | input | 1 | Read data valid |

## Verification
The bench builds the engine with ADDR_W = 32, FRAME_W = 16, BYTE_W = 8, HDR_ADDR = 0 and DEF_MAP_LEN = 256. The memory model holds 4096 words and the map regions are placed inside it. Revision 1 phases use the 256-byte default length, so byte offsets up to 15 and both halfword lanes are reached. Revision 2 phases take a 64-byte length from the header while the default is 256, which shows which of the two lengths is applied. Every tag width from 1 to 8 is exercised, including entries whose tags sit at the top bits of a word. Random waitrequest stalls and read latencies of 1 to 3 cycles test the bus hold and the single-outstanding rule.

// File: rtl/seu_map_pkg.sv
package seu_map_pkg;
  localparam logic [23:0] MAP_MAGIC = 24'h445341;
  localparam int unsigned HDR_WORDS = 5;
  localparam int unsigned HDR_IDX_W = $clog2(HDR_WORDS);
  localparam logic [15:0] NO_SENS_IDX = 16'hFFFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_FRAME, ST_MAP, ST_SENS, ST_DONE
  } lkp_state_e;

  // tag width in bits -> log2; valid flag in bit 2
  function automatic logic [2:0] width_dec(input logic [7:0] w);
    case (w)
      8'd1: return 3'b100;
      8'd2: return 3'b101;
      8'd4: return 3'b110;
      8'd8: return 3'b111;
      default: return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/seu_rd_port.sv
module seu_rd_port #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              idle_o,
  output logic              done_o,
  output logic [31:0]       data_o,
  output logic [ADDR_W-1:0] avm_address_o,
  output logic              avm_read_o,
  input  logic [31:0]       avm_readdata_i,
  input  logic              avm_waitrequest_i,
  input  logic              avm_readdatavalid_i
);
  logic              req_q, wait_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      wait_q <= 1'b0;
      addr_q <= '0;
    end else if (start_i && idle_o) begin
      req_q  <= 1'b1;
      addr_q <= addr_i;
    end else if (req_q && !avm_waitrequest_i) begin
      req_q  <= 1'b0;
      wait_q <= 1'b1;
    end else if (wait_q && avm_readdatavalid_i) begin
      wait_q <= 1'b0;
    end
  end

  assign idle_o        = !req_q && !wait_q;
  assign done_o        = wait_q && avm_readdatavalid_i;
  assign data_o        = avm_readdata_i;
  assign avm_address_o = addr_q;
  assign avm_read_o    = req_q;
endmodule

// File: rtl/seu_addr_calc.sv
module seu_addr_calc #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned BYTE_W  = 8
) (
  input  logic [ADDR_W-1:0]  frame_base_i,
  input  logic [ADDR_W-1:0]  off_base_i,
  input  logic [ADDR_W-1:0]  sens_base_i,
  input  logic [15:0]        map_len_i,
  input  logic [15:0]        map_idx_i,
  input  logic [15:0]        entry_i,
  input  logic [1:0]         lg_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [BYTE_W-1:0]  byte_i,
  input  logic [2:0]         bit_i,
  output logic [ADDR_W-1:0]  frame_addr_o,
  output logic [ADDR_W-1:0]  map_addr_o,
  output logic               half_hi_o,
  output logic [ADDR_W-1:0]  sens_addr_o,
  output logic [4:0]         sens_sh_o
);
  localparam int unsigned POS_W = BYTE_W + 4;

  logic [POS_W-1:0] in_map_off;
  logic [31:0]      map_off, bit_pos;
  logic             lsb_unused;

  assign in_map_off   = {byte_i, bit_i, 1'b0};
  assign map_off      = 32'(map_idx_i) * 32'(map_len_i) + 32'(in_map_off);
  assign map_addr_o   = off_base_i + ADDR_W'(map_off[31:2]);
  assign half_hi_o    = map_off[1];
  assign lsb_unused   = map_off[0];
  assign bit_pos      = 32'(entry_i) << lg_i;
  assign sens_addr_o  = sens_base_i + ADDR_W'(bit_pos[31:5]);
  assign sens_sh_o    = bit_pos[4:0];
  assign frame_addr_o = frame_base_i + ADDR_W'(frame_i);
endmodule

// File: rtl/seu_tag_extract.sv
module seu_tag_extract (
  input  logic [31:0] word_i,
  input  logic [4:0]  sh_i,
  input  logic [1:0]  lg_i,
  output logic [7:0]  tag_o
);
  logic [31:0] shifted;
  logic [23:0] shifted_unused;
  logic [7:0]  cand [4];

  assign shifted        = word_i >> sh_i;
  assign shifted_unused = shifted[31:8];

  for (genvar g = 0; g < 4; g++) begin : g_width
    assign cand[g] = 8'(shifted[(1 << g) - 1:0]);
  end

  assign tag_o = cand[lg_i];
endmodule

// File: rtl/seu_map_lookup.sv
module seu_map_lookup
  import seu_map_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned FRAME_W     = 16,
  parameter int unsigned BYTE_W      = 8,
  parameter logic [31:0] HDR_ADDR    = 32'h0,
  parameter logic [15:0] DEF_MAP_LEN = 16'd4096
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               err_valid_i,
  output logic               err_ready_o,
  input  logic [FRAME_W-1:0] err_frame_i,
  input  logic [BYTE_W-1:0]  err_byte_i,
  input  logic [2:0]         err_bit_i,
  output logic               crit_o,
  output logic               noncrit_o,
  output logic [7:0]         region_o,
  output logic               map_err_o,
  output logic [ADDR_W-1:0]  avm_address_o,
  output logic               avm_read_o,
  input  logic [31:0]        avm_readdata_i,
  input  logic               avm_waitrequest_i,
  input  logic               avm_readdatavalid_i
);
  lkp_state_e           st_q;
  logic [HDR_IDX_W-1:0] hdr_idx_q;
  logic                 hdr_done_q, map_err_q, rev2_q;
  logic [ADDR_W-1:0]    frame_base_q, off_base_q, sens_base_q;
  logic [15:0]          map_len_q, map_idx_q, entry_q;
  logic [1:0]           lg_q;
  logic [FRAME_W-1:0]   frame_q;
  logic [BYTE_W-1:0]    byte_q;
  logic [2:0]           bit_q;
  logic                 res_crit_q;
  logic [7:0]           res_tag_q;

  logic                 rd_start, rd_idle, rd_done;
  logic [31:0]          rd_data;
  logic [ADDR_W-1:0]    rd_addr, frame_addr, map_addr, sens_addr;
  logic                 half_hi;
  logic [4:0]           sens_sh;
  logic [7:0]           tag;
  logic [2:0]           wdec;
  logic                 data_unused;

  assign data_unused = ^rd_data;
  assign wdec        = width_dec(rd_data[23:16]);

  seu_rd_port #(.ADDR_W(ADDR_W)) u_rd (
    .clk_i, .rst_ni,
    .start_i(rd_start), .addr_i(rd_addr), .idle_o(rd_idle),
    .done_o(rd_done), .data_o(rd_data),
    .avm_address_o, .avm_read_o, .avm_readdata_i,
    .avm_waitrequest_i, .avm_readdatavalid_i
  );

  seu_addr_calc #(.ADDR_W(ADDR_W), .FRAME_W(FRAME_W), .BYTE_W(BYTE_W)) u_calc (
    .frame_base_i(frame_base_q), .off_base_i(off_base_q), .sens_base_i(sens_base_q),
    .map_len_i(map_len_q), .map_idx_i(map_idx_q), .entry_i(entry_q), .lg_i(lg_q),
    .frame_i(frame_q), .byte_i(byte_q), .bit_i(bit_q),
    .frame_addr_o(frame_addr), .map_addr_o(map_addr), .half_hi_o(half_hi),
    .sens_addr_o(sens_addr), .sens_sh_o(sens_sh)
  );

  seu_tag_extract u_tag (
    .word_i(rd_data), .sh_i(sens_sh), .lg_i(lg_q), .tag_o(tag)
  );

  assign rd_start = (st_q inside {ST_HDR, ST_FRAME, ST_MAP, ST_SENS}) && rd_idle;

  always_comb begin
    case (st_q)
      ST_HDR:   rd_addr = ADDR_W'(HDR_ADDR) + ADDR_W'(hdr_idx_q);
      ST_FRAME: rd_addr = frame_addr;
      ST_MAP:   rd_addr = map_addr;
      default:  rd_addr = sens_addr;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      hdr_idx_q    <= '0;
      hdr_done_q   <= 1'b0;
      map_err_q    <= 1'b0;
      rev2_q       <= 1'b0;
      frame_base_q <= '0;
      off_base_q   <= '0;
      sens_base_q  <= '0;
      map_len_q    <= '0;
      map_idx_q    <= '0;
      entry_q      <= '0;
      lg_q         <= '0;
      frame_q      <= '0;
      byte_q       <= '0;
      bit_q        <= '0;
      res_crit_q   <= 1'b0;
      res_tag_q    <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (err_valid_i) begin
          frame_q <= err_frame_i;
          byte_q  <= err_byte_i;
          bit_q   <= err_bit_i;
          if (!hdr_done_q) begin
            st_q      <= ST_HDR;
            hdr_idx_q <= '0;
          end else if (map_err_q) begin
            res_crit_q <= 1'b1;
            res_tag_q  <= '0;
            st_q       <= ST_DONE;
          end else begin
            st_q <= ST_FRAME;
          end
        end
        ST_HDR: if (rd_done) begin
          hdr_idx_q <= hdr_idx_q + 1'b1;
          case (hdr_idx_q)
            0: begin
              if (rd_data[23:0] != MAP_MAGIC ||
                  !(rd_data[31:24] inside {8'd1, 8'd2})) begin
                map_err_q  <= 1'b1;
                hdr_done_q <= 1'b1;
                res_crit_q <= 1'b1;
                res_tag_q  <= '0;
                st_q       <= ST_DONE;
              end
              rev2_q <= (rd_data[31:24] == 8'd2);
            end
            1: frame_base_q <= rd_data[ADDR_W-1:0];
            2: off_base_q   <= rd_data[ADDR_W-1:0];
            3: sens_base_q  <= rd_data[ADDR_W-1:0];
            default: begin
              map_len_q  <= rev2_q ? rd_data[15:0] : DEF_MAP_LEN;
              lg_q       <= wdec[1:0];
              hdr_done_q <= 1'b1;
              if (!wdec[2]) begin
                map_err_q  <= 1'b1;
                res_crit_q <= 1'b1;
                res_tag_q  <= '0;
                st_q       <= ST_DONE;
              end else begin
                st_q <= ST_FRAME;
              end
            end
          endcase
        end
        ST_FRAME: if (rd_done) begin
          map_idx_q <= rd_data[15:0];
          if (rd_data[15:0] == NO_SENS_IDX) begin
            res_crit_q <= 1'b0;
            res_tag_q  <= '0;
            st_q       <= ST_DONE;
          end else begin
            st_q <= ST_MAP;
          end
        end
        ST_MAP: if (rd_done) begin
          entry_q <= half_hi ? rd_data[31:16] : rd_data[15:0];
          st_q    <= ST_SENS;
        end
        ST_SENS: if (rd_done) begin
          res_crit_q <= (tag != 8'd0);
          res_tag_q  <= tag;
          st_q       <= ST_DONE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign err_ready_o = (st_q == ST_IDLE);
  assign crit_o      = (st_q == ST_DONE) && res_crit_q;
  assign noncrit_o   = (st_q == ST_DONE) && !res_crit_q;
  assign region_o    = crit_o ? res_tag_q : 8'd0;
  assign map_err_o   = map_err_q;
endmodule

// File: rtl/seu_map_lookup_chk.sv
module seu_map_lookup_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              err_valid_i,
  input logic              err_ready_o,
  input logic              crit_o,
  input logic              noncrit_o,
  input logic [7:0]        region_o,
  input logic              map_err_o,
  input logic [ADDR_W-1:0] avm_address_o,
  input logic              avm_read_o,
  input logic              avm_waitrequest_i,
  input logic              avm_readdatavalid_i
);
  logic [1:0] outst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) outst_q <= '0;
    else outst_q <= outst_q + 2'((avm_read_o && !avm_waitrequest_i) ? 1 : 0)
                            - 2'(avm_readdatavalid_i ? 1 : 0);
  end

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avm_read_o && avm_waitrequest_i |=> avm_read_o && $stable(avm_address_o));
  assert_one_out_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avm_read_o |-> outst_q == 2'd0);
  assert_rdv_match_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avm_readdatavalid_i |-> outst_q == 2'd1);
  assert_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(crit_o && noncrit_o));
  assert_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crit_o || noncrit_o) |=> !(crit_o || noncrit_o));
  assert_region_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !crit_o |-> region_o == 8'd0);
  assert_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_i && err_ready_o |=> !err_ready_o);
  assert_res_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crit_o || noncrit_o) |-> !err_ready_o ##1 err_ready_o);
  assert_idle_bus_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_ready_o |-> !avm_read_o && outst_q == 2'd0);
  assert_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_err_o |=> map_err_o);
endmodule

bind seu_map_lookup seu_map_lookup_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .err_valid_i(err_valid_i), .err_ready_o(err_ready_o),
  .crit_o(crit_o), .noncrit_o(noncrit_o), .region_o(region_o), .map_err_o(map_err_o),
  .avm_address_o(avm_address_o), .avm_read_o(avm_read_o),
  .avm_waitrequest_i(avm_waitrequest_i), .avm_readdatavalid_i(avm_readdatavalid_i)
);

// File: tb/seu_map_lookup_tb.sv
module seu_map_lookup_tb;
  localparam int ADDR_W = 32, FRAME_W = 16, BYTE_W = 8;
  localparam logic [15:0] DEF_LEN = 16'd256;
  localparam int FB = 'h100, OB = 'h200, SB = 'h400;
  localparam logic [23:0] MAGIC = 24'h445341;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic               valid = 1'b0, ready;
  logic [FRAME_W-1:0] frame = '0;
  logic [BYTE_W-1:0]  byte_off = '0;
  logic [2:0]         bit_off = '0;
  logic               crit, noncrit, map_err;
  logic [7:0]         region;
  logic [ADDR_W-1:0]  addr;
  logic               rd, wreq = 1'b0, rdv = 1'b0;
  logic [31:0]        rdata = '0;

  seu_map_lookup #(.ADDR_W(ADDR_W), .FRAME_W(FRAME_W), .BYTE_W(BYTE_W),
                   .HDR_ADDR(32'h0), .DEF_MAP_LEN(DEF_LEN)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .err_valid_i(valid), .err_ready_o(ready),
    .err_frame_i(frame), .err_byte_i(byte_off), .err_bit_i(bit_off),
    .crit_o(crit), .noncrit_o(noncrit), .region_o(region), .map_err_o(map_err),
    .avm_address_o(addr), .avm_read_o(rd), .avm_readdata_i(rdata),
    .avm_waitrequest_i(wreq), .avm_readdatavalid_i(rdv)
  );

  logic [31:0] mem [0:4095];
  int rd_cnt = 0, total = 0, bad = 0, cyc = 0;
  logic       pend = 1'b0;
  int         lat = 0;
  logic [11:0] pend_a = '0;

  // memory slave: random stalls, latency 1..3
  always @(posedge clk) begin
    rdv <= 1'b0;
    if (pend) begin
      if (lat == 1) begin
        rdv <= 1'b1;
        rdata <= mem[pend_a];
        pend <= 1'b0;
      end else lat <= lat - 1;
    end
    if (rd && !wreq) begin
      rd_cnt++;
      pend <= 1'b1;
      lat <= 1 + int'($urandom % 3);
      pend_a <= addr[11:0];
    end
    wreq <= ($urandom % 4) == 0;
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
      finish_run();
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_hdr(input logic [31:0] id, input logic [7:0] w, input logic [15:0] len);
    mem[0] = id; mem[1] = FB; mem[2] = OB; mem[3] = SB;
    mem[4] = {8'h5A, w, len};
  endtask

  // build the map path for one location from the requirements
  task automatic plant(input int fr, input int idx, input int by, input int bi,
                       input int entry, input int w, input int len, input logic [7:0] tg);
    int off, pos, sw;
    mem[FB + fr] = {16'($urandom), 16'(idx)};
    off = idx * len + (by * 8 + bi) * 2;
    mem[OB + off / 4][16 * ((off / 2) % 2) +: 16] = 16'(entry);
    pos = entry * w;
    sw = SB + pos / 32;
    for (int k = 0; k < w; k++) mem[sw][(pos % 32) + k] = tg[k];
  endtask

  task automatic lookup(input int fr, input int by, input int bi,
                        output logic cr, output logic nc, output logic [7:0] rg, output int nr);
    int r0, n;
    r0 = rd_cnt;
    cr = 0; nc = 0; rg = 0;
    frame = FRAME_W'(fr); byte_off = BYTE_W'(by); bit_off = 3'(bi);
    valid = 1'b1;
    n = 0;
    while (!ready && n < 2000) begin @(negedge clk); n++; end
    @(negedge clk);
    valid = 1'b0;
    chk("R9", "ready low after accept", ready, 0);
    n = 0;
    while (!(crit || noncrit) && n < 2000) begin @(negedge clk); n++; end
    if (n >= 2000) begin
      total++; bad++;
      $display("FAIL R9 result timeout: act=none exp=pulse");
    end
    cr = crit; nc = noncrit; rg = region;
    chk("R9", "ready low in result cycle", ready, 0);
    nr = rd_cnt - r0;
    @(negedge clk);
    chk("R9", "ready back after result", ready, 1);
    chk("R7", "single-cycle result", crit | noncrit, 0);
  endtask

  task automatic run_one(input int fr, input int by, input int bi, input logic ecrit,
                         input logic [7:0] etag, input int ereads, input string req);
    logic cr, nc; logic [7:0] rg; int nr;
    lookup(fr, by, bi, cr, nc, rg, nr);
    chk(req, "crit", cr, ecrit);
    chk(req, "noncrit", nc, !ecrit);
    chk(req, "region", rg, ecrit ? etag : 8'd0);
    chk("R10", "bus reads", nr, ereads);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    set_hdr({8'd2, MAGIC}, 8'd4, 16'd64);
    do_reset();
    chk("R9", "reset ready", ready, 1);
    chk("R7", "reset crit", crit, 0);
    chk("R7", "reset noncrit", noncrit, 0);
    chk("R11", "reset map_err", map_err, 0);
    repeat (10) @(negedge clk);
    chk("R10", "no reads before lookup", rd_cnt, 0);

    // every tag width, both revisions (R2 R3 R4 R5 R6 R7)
    for (int wi = 0; wi < 4; wi++) begin
      int w, rev, len, first;
      w = 1 << wi;
      rev = (wi % 2) ? 1 : 2;
      len = (rev == 2) ? 64 : int'(DEF_LEN);
      set_hdr({8'(rev), MAGIC}, 8'(w), (rev == 2) ? 16'd64 : 16'h1234);
      do_reset();
      first = 1;
      for (int n = 0; n < 25; n++) begin
        int fr, idx, by, bi, en; logic [7:0] tg;
        fr = int'($urandom % 256); idx = int'($urandom % 8);
        by = int'($urandom % ((rev == 2) ? 4 : 16)); bi = int'($urandom % 8);
        en = int'($urandom % (8192 / w));
        tg = 8'($urandom) & 8'((1 << w) - 1);
        plant(fr, idx, by, bi, en, w, len, tg);
        run_one(fr, by, bi, tg != 0, tg, first ? 8 : 3, "R6");
        first = 0;
      end
      // upper halfword lane, tag at top of a word
      plant(7, 1, 0, 1, (32 / w) - 1, w, len, 8'((1 << w) - 1));
      run_one(7, 0, 1, 1'b1, 8'((1 << w) - 1), 3, "R5");
      // frame without sensitive bits
      mem[FB + 9] = {16'h00C3, 16'hFFFF};
      run_one(9, 2, 3, 1'b0, 8'd0, 1, "R4");
      chk("R11", "map_err low on good header", map_err, 0);
    end

    // bad identifier
    set_hdr({8'd2, 24'h445342}, 8'd4, 16'd64);
    do_reset();
    run_one(3, 0, 0, 1'b1, 8'd0, 1, "R1");
    chk("R1", "map_err after bad id", map_err, 1);
    run_one(4, 1, 1, 1'b1, 8'd0, 0, "R11");
    chk("R11", "map_err sticky", map_err, 1);

    // bad revision
    set_hdr({8'd3, MAGIC}, 8'd4, 16'd64);
    do_reset();
    run_one(3, 0, 0, 1'b1, 8'd0, 1, "R2");
    chk("R2", "map_err after bad revision", map_err, 1);

    // bad tag width
    set_hdr({8'd2, MAGIC}, 8'd3, 16'd64);
    do_reset();
    run_one(3, 0, 0, 1'b1, 8'd0, 5, "R3");
    chk("R3", "map_err after bad width", map_err, 1);

    // reset clears the error and forces a fresh header read
    set_hdr({8'd2, MAGIC}, 8'd8, 16'd64);
    do_reset();
    chk("R11", "map_err cleared by reset", map_err, 0);
    plant(20, 2, 1, 5, 40, 8, 64, 8'hA7);
    run_one(20, 1, 5, 1'b1, 8'hA7, 8, "R10");
    plant(21, 3, 3, 7, 0, 8, 64, 8'h00);
    run_one(21, 3, 7, 1'b0, 8'h00, 3, "R7");

    finish_run();
  end
endmodule